// File: doc/BRIEF.md
# Vertical Linear-Phase Line Interpolator

This block reduces the number of lines in a video frame by any factor between one and one half. Pixels arrive as a raster stream, one pixel per valid cycle. A flag marks the first pixel of each line, and a second flag marks the first line of a frame. The block keeps the line before the current one in an internal store. For each output line it mixes that stored line with the incoming one, using a weight in 64ths of a line. The mixed result leaves as a pixel stream, one cycle behind the input.

A phase accumulator holds the geometric position of the next output line in 1/1024-line units. It starts at a programmed start phase and advances by a programmed increment once per emitted line. The integer part of the accumulator selects the line pair. The fractional part supplies the weight. An increment of zero turns the block into a per-line pass-through, or into a fixed two-line smoother. Interlaced sources use one start phase per field. A mirror option emits each interpolated line with its pixel order reversed. That line comes out while the next input line streams in, so the last line of a frame is never shown.

Top module: `vlpi_scaler`

## Requirements
- R1: During reset and in the first cycle after it, out_valid and out_sol are 0.
- R2: Every output pixel appears exactly one clock after the input pixel whose slot carries it. out_sol is high only on the pixel at line position 0.
- R3: A mixed pixel equals (w·cur + (64−w)·prev + 32) >> 6, saturated to 255. Here cur is the incoming line, prev is the stored line at the same position, and w is the weight, 0 to 64.
- R4: At the first line of a frame the position register loads start_phase·16. It grows by cfg_incr after each emitted line. For position p, the line pair is (p>>10, p>>10 + 1) and w = (p>>4) mod 64.
- R5: With a nonzero increment, an output line is emitted while input line (p>>10)+1 streams in, and never during the first input line of a frame. The supported increments are 0 and 1024 to 2048.
- R6: With an increment of 0 and a start phase of 64, each output line equals its input line, pixel for pixel.
- R7: With an increment of 0 and a start phase below 64, line 0 passes through unchanged. Every later line k is mixed from lines k−1 and k with w equal to the start phase. Output line count equals input line count.
- R8: The start phase is chosen at the frame's first pixel. in_field=0 selects cfg_phase_odd and in_field=1 selects cfg_phase_even.
- R9: Pixels at line positions at or beyond cfg_len (maximum 384) are neither stored nor output.
- R10: With cfg_mirror=1, each line that R4–R7 would emit is output reversed (position j carries position cfg_len−1−j) during the next input line. A line emitted during the last input line of a frame is never output.
- R11: The first line of a frame restarts the position register and line count, and discards a mirrored line still pending from the previous frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_incr | input | INCR_W | Position increment per output line, 1/1024-line units |
| cfg_phase_odd | input | 7 | Start phase for field 0, in 64ths of a line |
| cfg_phase_even | input | 7 | Start phase for field 1, in 64ths of a line |
| cfg_mirror | input | 1 | Reverse pixel order of output lines |
| cfg_len | input | LEN_W | Pixels per line used, at most MAX_PIX |
| in_sof | input | 1 | First line of frame (valid with in_sol) |
| in_field | input | 1 | Field of the frame, sampled with in_sof |
| in_sol | input | 1 | First pixel of a line (valid with in_valid) |
| in_valid | input | 1 | Input pixel present |
| in_pix | input | 8 | Input pixel |
| out_valid | output | 1 | Output pixel present |
| out_sol | output | 1 | First pixel of an output line |
| out_pix | output | 8 | Output pixel |

## Verification
A wrong position register or line counter does not show at the pixel it corrupts. It shows one input line later, as an output line that is missing, extra, or mixed with the wrong weight. The bench therefore compares the whole ordered pixel stream of each frame and checks that nothing is left over at frame end. A fault in the stored line or in the mirror banks shows as wrong pixel values one cycle after the affected input pixel. In mirror mode, an error in the bank select shows during the next line, as a reversed copy of the wrong line.

// File: rtl/vlpi_pkg.sv
package vlpi_pkg;
    localparam int PIX_W    = 8;
    localparam int WGT_W    = 6;
    localparam int PH_W     = WGT_W + 1;
    localparam int FRAC_W   = 10;
    localparam int PH_SHIFT = FRAC_W - WGT_W;
    localparam int ONE      = 1 << WGT_W;
    localparam int ACC_W    = PIX_W + WGT_W + 2;
    localparam int PIX_MAX  = (1 << PIX_W) - 1;

    // per-line decision made at the first pixel of each input line
    typedef struct packed {
        logic            emit;   // this input line produces an output line
        logic            show;   // previous line produced one (mirror playback)
        logic            bank;   // parity of this input line
        logic [PH_W-1:0] wgt;    // weight of the incoming line, 0..ONE
    } line_plan_t;

    function automatic logic [PIX_W-1:0] lpi_mix(
        input logic [PIX_W-1:0] prev,
        input logic [PIX_W-1:0] cur,
        input logic [PH_W-1:0]  wgt
    );
        logic [ACC_W-1:0] acc;
        logic [PH_W-1:0]  wcomp;
        wcomp = PH_W'(ONE) - wgt;
        acc = ACC_W'(wgt) * ACC_W'(cur) + ACC_W'(wcomp) * ACC_W'(prev)
            + ACC_W'(ONE / 2);
        acc = acc >> WGT_W;
        if (acc > ACC_W'(PIX_MAX))
            acc = ACC_W'(PIX_MAX);
        return acc[PIX_W-1:0];
    endfunction
endpackage

// File: rtl/vlpi_linestore.sv
module vlpi_linestore #(
    parameter int DEPTH = 384,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    // read returns the contents before this cycle's write
    assign rdata = mem[raddr];
endmodule

// File: rtl/vlpi_blend.sv
module vlpi_blend import vlpi_pkg::*; (
    input  logic [PIX_W-1:0] prev,
    input  logic [PIX_W-1:0] cur,
    input  logic [PH_W-1:0]  wgt,
    output logic [PIX_W-1:0] mixed
);
    always_comb mixed = lpi_mix(prev, cur, wgt);
endmodule

// File: rtl/vlpi_phase.sv
module vlpi_phase import vlpi_pkg::*; #(
    parameter int INCR_W = 13,
    parameter int POS_W  = 22
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_start,
    input  logic              frame_start,
    input  logic              field,
    input  logic [INCR_W-1:0] incr,
    input  logic [PH_W-1:0]   ph_odd,
    input  logic [PH_W-1:0]   ph_even,
    output line_plan_t        plan_now
);
    localparam int INT_W = POS_W - FRAC_W;

    logic [POS_W-1:0] pos_q, pos_eff;
    logic [INT_W-1:0] line_q, k_eff, int_part;
    logic [PH_W-1:0]  ph_q, ph_sel, ph_eff;
    line_plan_t       plan_q, plan_c;
    logic             zero_incr;

    always_comb begin
        ph_sel    = field ? ph_even : ph_odd;
        ph_eff    = frame_start ? ph_sel : ph_q;
        pos_eff   = frame_start ? (POS_W'(ph_sel) << PH_SHIFT) : pos_q;
        k_eff     = frame_start ? '0 : line_q;
        int_part  = pos_eff[POS_W-1:FRAC_W];
        zero_incr = (incr == '0);

        plan_c.bank = k_eff[0];
        plan_c.show = frame_start ? 1'b0 : plan_q.emit;
        if (zero_incr) begin
            plan_c.emit = 1'b1;
            if (k_eff == '0 || ph_eff > PH_W'(ONE))
                plan_c.wgt = PH_W'(ONE);
            else
                plan_c.wgt = ph_eff;
        end else begin
            plan_c.emit = (k_eff != '0) && (int_part == k_eff - 1'b1);
            plan_c.wgt  = {1'b0, pos_eff[FRAC_W-1:PH_SHIFT]};
        end

        plan_now = line_start ? plan_c : plan_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q  <= '0;
            line_q <= '0;
            ph_q   <= '0;
            plan_q <= '0;
        end else if (line_start) begin
            plan_q <= plan_c;
            line_q <= k_eff + 1'b1;
            ph_q   <= ph_eff;
            pos_q  <= (plan_c.emit && !zero_incr) ? pos_eff + POS_W'(incr) : pos_eff;
        end
    end
endmodule

// File: rtl/vlpi_scaler.sv
module vlpi_scaler import vlpi_pkg::*; #(
    parameter int MAX_PIX = 384,
    parameter int INCR_W  = 13,
    parameter int POS_W   = 22,
    localparam int LEN_W  = $clog2(MAX_PIX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [INCR_W-1:0] cfg_incr,
    input  logic [PH_W-1:0]   cfg_phase_odd,
    input  logic [PH_W-1:0]   cfg_phase_even,
    input  logic              cfg_mirror,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              in_sof,
    input  logic              in_field,
    input  logic              in_sol,
    input  logic              in_valid,
    input  logic [PIX_W-1:0]  in_pix,
    output logic              out_valid,
    output logic              out_sol,
    output logic [PIX_W-1:0]  out_pix
);
    localparam int ADDR_W = $clog2(MAX_PIX);

    logic             line_start, frame_start;
    line_plan_t       plan;
    logic [LEN_W-1:0] idx_q, cur_idx, mir_idx;
    logic             in_range;
    logic [ADDR_W-1:0] addr, mir_addr;
    logic [PIX_W-1:0] prev_pix, mix_pix, play_pix;
    logic [PIX_W-1:0] bank_rd [2];
    logic             nxt_valid;

    assign line_start  = in_valid & in_sol;
    assign frame_start = line_start & in_sof;

    vlpi_phase #(.INCR_W(INCR_W), .POS_W(POS_W)) u_phase (
        .clk        (clk),
        .rst        (rst),
        .line_start (line_start),
        .frame_start(frame_start),
        .field      (in_field),
        .incr       (cfg_incr),
        .ph_odd     (cfg_phase_odd),
        .ph_even    (cfg_phase_even),
        .plan_now   (plan)
    );

    // pixel position within the current line
    always_comb begin
        cur_idx  = line_start ? '0 : idx_q;
        in_range = in_valid && (cur_idx < cfg_len) && (cur_idx < LEN_W'(MAX_PIX));
        mir_idx  = cfg_len - 1'b1 - cur_idx;
        addr     = cur_idx[ADDR_W-1:0];
        mir_addr = mir_idx[ADDR_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            idx_q <= '0;
        else if (in_valid && cur_idx < LEN_W'(MAX_PIX))
            idx_q <= cur_idx + 1'b1;
    end

    // previous input line
    vlpi_linestore #(.DEPTH(MAX_PIX), .W(PIX_W)) u_prev (
        .clk  (clk),
        .we   (in_range),
        .waddr(addr),
        .wdata(in_pix),
        .raddr(addr),
        .rdata(prev_pix)
    );

    vlpi_blend u_mix (
        .prev (prev_pix),
        .cur  (in_pix),
        .wgt  (plan.wgt),
        .mixed(mix_pix)
    );

    // two result banks for reversed playback, indexed by line parity
    for (genvar b = 0; b < 2; b++) begin : g_bank
        vlpi_linestore #(.DEPTH(MAX_PIX), .W(PIX_W)) u_res (
            .clk  (clk),
            .we   (in_range && plan.emit && cfg_mirror && (plan.bank == 1'(b))),
            .waddr(addr),
            .wdata(mix_pix),
            .raddr(mir_addr),
            .rdata(bank_rd[b])
        );
    end

    assign play_pix  = bank_rd[~plan.bank];
    assign nxt_valid = in_range && (cfg_mirror ? plan.show : plan.emit);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_sol   <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_valid <= nxt_valid;
            out_sol   <= nxt_valid && (cur_idx == '0);
            out_pix   <= cfg_mirror ? play_pix : mix_pix;
        end
    end
endmodule

// File: rtl/vlpi_scaler_chk.sv
module vlpi_scaler_chk #(
    parameter int INCR_W = 13,
    parameter int LEN_W  = 9,
    parameter int PIX_W  = 8,
    parameter int PH_W   = 7
) (
    input logic              clk,
    input logic              rst,
    input logic [INCR_W-1:0] cfg_incr,
    input logic [PH_W-1:0]   cfg_phase_odd,
    input logic [PH_W-1:0]   cfg_phase_even,
    input logic              cfg_mirror,
    input logic [LEN_W-1:0]  cfg_len,
    input logic              in_valid,
    input logic [PIX_W-1:0]  in_pix,
    input logic              out_valid,
    input logic              out_sol,
    input logic [PIX_W-1:0]  out_pix
);
    logic [LEN_W-1:0] seen;

    always_ff @(posedge clk) begin
        if (rst)
            seen <= '0;
        else if (out_valid)
            seen <= out_sol ? LEN_W'(1) : seen + 1'b1;
    end

    assert_idle_after_reset_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_sol));

    assert_one_cycle_latency_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    assert_sol_qualified_R2: assert property (@(posedge clk) disable iff (rst)
        out_sol |-> out_valid);

    assert_bypass_copy_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !cfg_mirror && cfg_incr == '0 &&
         cfg_phase_odd == PH_W'(64) && cfg_phase_even == PH_W'(64))
        |-> out_pix == $past(in_pix));

    assert_line_len_bound_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_sol) |-> (seen < cfg_len));
endmodule

bind vlpi_scaler vlpi_scaler_chk #(
    .INCR_W(INCR_W), .LEN_W(LEN_W), .PIX_W(vlpi_pkg::PIX_W), .PH_W(vlpi_pkg::PH_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cfg_incr      (cfg_incr),
    .cfg_phase_odd (cfg_phase_odd),
    .cfg_phase_even(cfg_phase_even),
    .cfg_mirror    (cfg_mirror),
    .cfg_len       (cfg_len),
    .in_valid      (in_valid),
    .in_pix        (in_pix),
    .out_valid     (out_valid),
    .out_sol       (out_sol),
    .out_pix       (out_pix)
);

// File: tb/sim_vlpi_scaler.sv
module sim_vlpi_scaler;
    localparam int MAXL  = 384;
    localparam int MAXN  = 8;
    localparam int LEN_W = 9;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [12:0] cfg_incr = '0;
    logic [6:0]  cfg_phase_odd = 7'd64, cfg_phase_even = 7'd64;
    logic        cfg_mirror = 1'b0;
    logic [LEN_W-1:0] cfg_len = 9'd8;
    logic        in_sof = 0, in_field = 0, in_sol = 0, in_valid = 0;
    logic [7:0]  in_pix = '0;
    logic        out_valid, out_sol;
    logic [7:0]  out_pix;

    int vectors = 0, fails = 0, cyc = 0;
    string cur_req = "R1";
    logic [7:0] frm [MAXN][MAXL];
    int exp_pix [$];
    bit exp_sol [$];
    bit lat_chk = 0;

    always #10 clk = ~clk;

    vlpi_scaler u0 (
        .clk(clk), .rst(rst), .cfg_incr(cfg_incr),
        .cfg_phase_odd(cfg_phase_odd), .cfg_phase_even(cfg_phase_even),
        .cfg_mirror(cfg_mirror), .cfg_len(cfg_len), .in_sof(in_sof),
        .in_field(in_field), .in_sol(in_sol), .in_valid(in_valid),
        .in_pix(in_pix), .out_valid(out_valid), .out_sol(out_sol),
        .out_pix(out_pix)
    );

    function automatic int mix(int prev, int cur, int w);
        int v;
        v = (w * cur + (64 - w) * prev + 32) >> 6;
        return (v > 255) ? 255 : v;
    endfunction

    task automatic push_line(int len, bit mir, int a, int b, int w);
        for (int j = 0; j < len; j++) begin
            int jj;
            jj = mir ? len - 1 - j : j;
            exp_pix.push_back(mix(frm[a][jj], frm[b][jj], w));
            exp_sol.push_back(j == 0);
        end
    endtask

    // expected stream from R3..R10
    task automatic build_expected(int nl, int len, int incr, int ph, bit mir);
        if (incr == 0) begin
            for (int k = 0; k < nl; k++) begin
                if (mir && k == nl - 1) break;
                if (k == 0) push_line(len, mir, 0, 0, 64);
                else        push_line(len, mir, k - 1, k, (ph > 64) ? 64 : ph);
            end
        end else begin
            for (int m = 0; m < 64; m++) begin
                int p, i;
                p = ph * 16 + m * incr;
                i = p >> 10;
                if (i + 1 >= nl) break;
                if (mir && i + 1 == nl - 1) break;
                push_line(len, mir, i, i + 1, (p >> 4) & 63);
            end
        end
    endtask

    always @(negedge clk) begin
        if (!rst && out_valid) begin
            vectors++;
            if (exp_pix.size() == 0) begin
                fails++;
                $display("FAIL %s: unexpected output pixel %0d, expected none", cur_req, out_pix);
            end else begin
                int e; bit s;
                e = exp_pix.pop_front();
                s = exp_sol.pop_front();
                if (out_pix !== 8'(e) || out_sol !== s) begin
                    fails++;
                    $display("FAIL %s: pix/sol %0d/%0b expected %0d/%0b", cur_req, out_pix, out_sol, e, s);
                end
            end
        end
    end

    task automatic send_frame(int nl, int npix, bit fld);
        for (int k = 0; k < nl; k++) begin
            for (int j = 0; j < npix; j++) begin
                int idle;
                idle = $urandom % 3;
                repeat (idle) @(negedge clk);
                in_valid = 1; in_sol = (j == 0); in_sof = (k == 0 && j == 0);
                in_field = fld; in_pix = frm[k][j];
                @(negedge clk);
                if (lat_chk) begin
                    // R2: output one clock after the input pixel
                    vectors++;
                    if (out_valid !== 1'b1 || out_pix !== frm[k][j] || out_sol !== (j == 0)) begin
                        fails++;
                        $display("FAIL R2: valid/pix %0b/%0d expected 1/%0d", out_valid, out_pix, frm[k][j]);
                    end
                end
                in_valid = 0; in_sol = 0; in_sof = 0;
            end
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic run_frame(string req, int nl, int len, int npix, int incr,
                             int phodd, int pheven, bit fld, bit mir);
        cur_req = req;
        cfg_incr = 13'(incr); cfg_phase_odd = 7'(phodd); cfg_phase_even = 7'(pheven);
        cfg_mirror = mir; cfg_len = LEN_W'(len);
        for (int k = 0; k < nl; k++)
            for (int j = 0; j < npix; j++)
                frm[k][j] = 8'($urandom);
        build_expected(nl, len, incr, fld ? pheven : phodd, mir);
        send_frame(nl, npix, fld);
        repeat (4) @(negedge clk);
        vectors++;
        if (exp_pix.size() != 0) begin
            fails++;
            $display("FAIL %s: %0d pixels missing, expected 0", req, exp_pix.size());
            exp_pix.delete(); exp_sol.delete();
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: cycle %0d expected below 150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1: outputs idle during and after reset
        vectors++;
        if (out_valid !== 1'b0 || out_sol !== 1'b0) begin
            fails++;
            $display("FAIL R1: valid/sol %0b/%0b expected 0/0", out_valid, out_sol);
        end
        rst = 0;
        @(negedge clk);
        vectors++;
        if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1: valid %0b expected 0", out_valid);
        end

        lat_chk = 1;
        run_frame("R6", 5, 8, 8, 0, 64, 64, 0, 0);          // bypass, R2 latency
        lat_chk = 0;
        run_frame("R7", 5, 8, 8, 0, 32, 32, 0, 0);          // average of two lines
        run_frame("R7", 4, 6, 6, 0, 0, 0, 0, 0);            // weight 0 keeps prev line
        run_frame("R3", 4, 6, 6, 0, 17, 17, 0, 0);          // odd weight rounding
        for (int f = 0; f < 6; f++) begin                   // R4 R5 R3 random downscale
            int inc, pa, pb;
            inc = 1024 + ($urandom % 1025);
            pa = $urandom % 65; pb = $urandom % 65;
            run_frame("R4", 8, 4 + ($urandom % 13), 0 + 16, inc, pa, pb, $urandom % 2, 0);
        end
        run_frame("R5", 6, 5, 5, 1024, 0, 0, 0, 0);         // unity step, line 0 silent
        run_frame("R5", 8, 5, 5, 2048, 64, 64, 0, 0);       // half height
        run_frame("R8", 8, 6, 6, 1536, 10, 50, 1, 0);       // even field phase
        run_frame("R8", 8, 6, 6, 1536, 10, 50, 0, 0);       // odd field phase
        run_frame("R9", 5, 5, 8, 1280, 16, 16, 0, 0);       // extra pixels dropped
        run_frame("R10", 6, 10, 10, 1536, 0, 0, 0, 1);      // mirrored downscale
        run_frame("R11", 6, 10, 10, 1536, 0, 0, 0, 1);      // pending line discarded
        run_frame("R10", 4, 7, 7, 0, 64, 64, 0, 1);         // mirrored bypass
        run_frame("R10", 3, 384, 384, 0, 32, 32, 0, 1);     // full-length mirror
        run_frame("R11", 5, 8, 8, 1100, 40, 40, 0, 0);      // restart after mirror

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule